// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between an on-chip requester and an external asynchronous static RAM of 64K bytes. The requester offers one read or one write at a time over a valid/ready handshake. The controller replays each request as a timed sequence on the memory pins: two chip selects of opposite polarity, an active-low output enable, an active-low write strobe, a 16-bit address and an 8-bit data bus. The data bus appears as separate out, enable and in vectors, and the tri-state pad is placed at the chip edge. A read returns its byte through a one-cycle response pulse.

Every phase of an access lasts a parameterised number of clock cycles. Each count is the memory's nanosecond minimum rounded up to whole clock periods. Between accesses the memory is always deselected. After a read, a fixed turnaround keeps the controller's data driver off while the memory's outputs float. A retention input parks the memory in the deselected state so that its supply can be lowered. When that input is released, the controller waits a programmable recovery time before it accepts new work.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, mem_ce1_n=1, mem_ce2=0, mem_oe_n=1, mem_we_n=1, mem_dq_oe=0, rsp_valid=0 and sleep_ack=0, and req_ready=1.
- R2: Outside read and write phases (idle, turnaround, retention, recovery wait), mem_ce1_n=1 and mem_ce2=0 together, and both always show opposite levels.
- R3: A read holds the memory selected with mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0 for exactly RD_CYC consecutive cycles, starting in the cycle after the handshake.
- R4: The read byte is sampled from mem_dq_in in the last strobe cycle. rsp_valid is high for exactly one cycle, in the first cycle after the strobe, with that byte on rsp_rdata.
- R5: A write spends AS_CYC selected cycles with mem_we_n=1, then drives mem_we_n=0 for exactly WP_CYC consecutive cycles. mem_we_n is low only while selected and with mem_oe_n=1.
- R6: mem_addr (and, for a write, mem_dq_out) carries the accepted request from the first selected cycle and does not change until the memory is deselected.
- R7: A write strobe ends by mem_we_n rising. Select, address and driven data then stay for TAIL cycles, where TAIL = max(WR_CYC, WC_CYC-AS_CYC-WP_CYC), so the whole selected window is at least WC_CYC cycles.
- R8: mem_dq_oe is high only while mem_oe_n=1. Its first cycle is preceded by at least TA_CYC cycles with mem_oe_n=1, so that after a read the memory has floated.
- R9: req_ready is high exactly when the controller is idle and sleep_req is low. A request is taken on req_valid and req_ready, and at least one deselected cycle separates two accesses.
- R10: sleep_req seen while idle wins over a request in the same cycle. From the next cycle the memory is deselected and sleep_ack=1. An access already running completes first.
- R11: After sleep_req falls, sleep_ack drops in the next cycle, and req_ready stays low for RECOV_CYC cycles before it returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Request to park the memory for supply lowering |
| sleep_ack | output | 1 | Memory is parked and deselected |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle read response |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 16 | Memory address lines |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Enable for the data pad driver |
| mem_dq_in | input | 8 | Data from the memory pad |

## Verification
Two functions can compete in one cycle. A retention request and a new access request can both arrive while the controller is idle, and a retention request can also arrive in the middle of a running access. The bench raises sleep_req on the same falling edge as req_valid, and again a few cycles into a read. Its cycle reference model expects retention to win in the first case, with the pending request taken only after the recovery wait. In the second case the model expects the read to run its full length and return its byte before sleep_ack rises. A behavioural memory in the bench supplies valid data only in the last strobe cycle. It also checks the strobe width, address stability and bus contention on the pins.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_TURN,
    ST_WSET,
    ST_WPUL,
    ST_WREC,
    ST_SLEEP,
    ST_WAKE
  } ctl_state_t;

  function automatic int cyc_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val - CNT_W'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign last = (cnt == '0);

  // R3
  timer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (last && !load) |=> last);

endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_wr,
  input  logic [DW-1:0] wdata,
  input  logic          capture,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] rdata,
  output logic          rsp_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_out    <= '0;
      rdata     <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= capture;
      if (load_wr) dq_out <= wdata;
      if (capture) rdata  <= dq_in;
    end
  end

  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_pin_reg.sv
module sram_pin_reg
  import sram_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ctl_state_t st_nxt,
  output logic       ce1_n,
  output logic       ce2,
  output logic       oe_n,
  output logic       we_n,
  output logic       dq_oe,
  output logic       park
);

  logic sel_d, rd_d, wp_d, drv_d, park_d;

  always_comb begin
    sel_d  = (st_nxt == ST_RD)   || (st_nxt == ST_WSET) ||
             (st_nxt == ST_WPUL) || (st_nxt == ST_WREC);
    rd_d   = (st_nxt == ST_RD);
    wp_d   = (st_nxt == ST_WPUL);
    drv_d  = (st_nxt == ST_WSET) || (st_nxt == ST_WPUL) || (st_nxt == ST_WREC);
    park_d = (st_nxt == ST_SLEEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ce1_n <= 1'b1;
      ce2   <= 1'b0;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
      park  <= 1'b0;
    end else begin
      ce1_n <= !sel_d;
      ce2   <= sel_d;
      oe_n  <= !rd_d;
      we_n  <= !wp_d;
      dq_oe <= drv_d;
      park  <= park_d;
    end
  end

  // R5
  we_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!ce1_n && ce2 && oe_n));

  // R8
  bus_clash_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> oe_n);

  // R7
  strobe_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (!ce1_n && ce2 && dq_oe));

  // R3
  read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (we_n && !dq_oe && !ce1_n));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int RD_CYC    = 12,
  parameter int AS_CYC    = 1,
  parameter int WP_CYC    = 7,
  parameter int WR_CYC    = 1,
  parameter int WC_CYC    = 12,
  parameter int TA_CYC    = 4,
  parameter int RECOV_CYC = 500000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sleep_req,
  output logic          sleep_ack,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce1_n,
  output logic          mem_ce2,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int TAIL_CYC = (WC_CYC > AS_CYC + WP_CYC + WR_CYC) ?
                            (WC_CYC - AS_CYC - WP_CYC) : WR_CYC;
  localparam int MAX_CYC  = cyc_max(cyc_max(cyc_max(RD_CYC, TA_CYC),
                                            cyc_max(AS_CYC, WP_CYC)),
                                    cyc_max(TAIL_CYC, RECOV_CYC));
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  ctl_state_t       st, st_nxt;
  logic             ld, last, accept, capture;
  logic [CNT_W-1:0] ld_val;

  assign req_ready = (st == ST_IDLE) && !sleep_req;

  always_comb begin
    st_nxt  = st;
    ld      = 1'b0;
    ld_val  = '0;
    accept  = 1'b0;
    capture = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (sleep_req) begin
          st_nxt = ST_SLEEP;
        end else if (req_valid) begin
          accept = 1'b1;
          ld     = 1'b1;
          if (req_write) begin
            st_nxt = ST_WSET;
            ld_val = CNT_W'(AS_CYC);
          end else begin
            st_nxt = ST_RD;
            ld_val = CNT_W'(RD_CYC);
          end
        end
      end
      ST_RD: if (last) begin
        capture = 1'b1;
        st_nxt  = ST_TURN;
        ld      = 1'b1;
        ld_val  = CNT_W'(TA_CYC);
      end
      ST_TURN: if (last) st_nxt = ST_IDLE;
      ST_WSET: if (last) begin
        st_nxt = ST_WPUL;
        ld     = 1'b1;
        ld_val = CNT_W'(WP_CYC);
      end
      ST_WPUL: if (last) begin
        st_nxt = ST_WREC;
        ld     = 1'b1;
        ld_val = CNT_W'(TAIL_CYC);
      end
      ST_WREC: if (last) st_nxt = ST_IDLE;
      ST_SLEEP: if (!sleep_req) begin
        st_nxt = ST_WAKE;
        ld     = 1'b1;
        ld_val = CNT_W'(RECOV_CYC);
      end
      ST_WAKE: if (last) st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      mem_addr <= '0;
    end else begin
      st <= st_nxt;
      if (accept) mem_addr <= req_addr;
    end
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .last     (last)
  );

  sram_pin_reg u_pins (
    .clk    (clk),
    .rst    (rst),
    .st_nxt (st_nxt),
    .ce1_n  (mem_ce1_n),
    .ce2    (mem_ce2),
    .oe_n   (mem_oe_n),
    .we_n   (mem_we_n),
    .dq_oe  (mem_dq_oe),
    .park   (sleep_ack)
  );

  sram_dq_path #(.DW(DW)) u_dq (
    .clk       (clk),
    .rst       (rst),
    .load_wr   (accept && req_write),
    .wdata     (req_wdata),
    .capture   (capture),
    .dq_in     (mem_dq_in),
    .dq_out    (mem_dq_out),
    .rdata     (rsp_rdata),
    .rsp_valid (rsp_valid)
  );

  // R2
  cs_polarity_chk: assert property (@(posedge clk) disable iff (rst)
    mem_ce1_n == !mem_ce2);

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce1_n && $past(!mem_ce1_n)) |-> $stable(mem_addr));

  // R8
  turnaround_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> ($past(mem_oe_n) && $past(mem_oe_n, 2)));

  // R10
  parked_chk: assert property (@(posedge clk) disable iff (rst)
    sleep_ack |-> (mem_ce1_n && !mem_ce2 && !req_ready));

  // R11
  wake_wait_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep_ack) |-> !req_ready);

endmodule

// File: tb/tb_sram_ctrl.sv
module tb_sram_ctrl;

  localparam int RD = 12, AS = 1, WP = 7, WR = 1, WC = 12, TA = 4, RV = 50;
  localparam int TAIL = (WC > AS + WP + WR) ? (WC - AS - WP) : WR;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  mem_dq_in = 8'hEE;
  logic sleep_ack, req_ready, rsp_valid;
  logic [7:0]  rsp_rdata, mem_dq_out;
  logic [15:0] mem_addr;
  logic mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;

  always #5 clk = ~clk;

  sram_ctrl #(.RD_CYC(RD), .AS_CYC(AS), .WP_CYC(WP), .WR_CYC(WR), .WC_CYC(WC),
              .TA_CYC(TA), .RECOV_CYC(RV)) dut (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .sleep_ack(sleep_ack),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n),
    .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  int checks = 0, fails = 0;
  bit ended = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // behavioural memory contents and reference shadow
  logic [7:0] mem_arr [int];
  logic [7:0] shadow  [int];

  function automatic logic [7:0] mem_rd(input int a);
    return mem_arr.exists(a) ? mem_arr[a] : 8'h00;
  endfunction
  function automatic logic [7:0] sh_rd(input int a);
    return shadow.exists(a) ? shadow[a] : 8'h00;
  endfunction

  // reference model: 0 idle,1 read,2 turn,3 setup,4 pulse,5 tail,6 parked,7 wake
  int ph = 0, left = 0;
  bit lat_wr = 0, rsp_exp = 0;
  logic [15:0] lat_addr = '0;
  logic [7:0]  lat_data = '0, rsp_dat = '0;

  // pin history for memory-side checks
  bit p_sel = 0, p_oe_n = 1, p_we_n = 1, p_dq_oe = 0;
  logic [15:0] p_addr = '0, run_addr = '0, wp_addr = '0;
  logic [7:0]  p_dq = '0, wp_data = '0;
  int age = 0, wp_cnt = 0, sel_run = 0, floatc = 100;
  bit saw_wr = 0;

  always @(posedge clk) begin
    bit cur_sel, exp_sel, rsp_n;
    string rtag;
    #1;
    // ---------- reference model step ----------
    if (rst) begin
      ph = 0; left = 0; rsp_exp = 0;
    end else begin
      rsp_n = 0;
      case (ph)
        0: if (sleep_req) ph = 6;
           else if (req_valid) begin
             lat_wr = req_write; lat_addr = req_addr; lat_data = req_wdata;
             if (req_write) begin ph = 3; left = AS; end
             else begin ph = 1; left = RD; end
           end
        1: begin left--; if (left == 0) begin ph = 2; left = TA; rsp_n = 1;
             rsp_dat = sh_rd(int'(lat_addr)); end end
        2: begin left--; if (left == 0) ph = 0; end
        3: begin left--; if (left == 0) begin ph = 4; left = WP; end end
        4: begin left--; if (left == 0) begin ph = 5; left = TAIL; end end
        5: begin left--; if (left == 0) begin ph = 0;
             shadow[int'(lat_addr)] = lat_data; end end
        6: if (!sleep_req) begin ph = 7; left = RV; end
        7: begin left--; if (left == 0) ph = 0; end
        default: ph = 0;
      endcase
      rsp_exp = rsp_n;
    end

    // ---------- memory-side monitors on the previous cycle ----------
    if (!rst) begin
      if (p_sel) begin
        if (sel_run == 0) run_addr = p_addr;
        else chk(p_addr == run_addr, "R6 addr moved while selected", p_addr, run_addr);
        sel_run++;
        if (!p_we_n) saw_wr = 1;
      end else if (sel_run > 0) begin
        if (saw_wr) chk(sel_run == AS + WP + TAIL && sel_run >= WC, "R7 write window", sel_run, AS + WP + TAIL);
        else chk(sel_run == RD, "R3 read window", sel_run, RD);
        sel_run = 0; saw_wr = 0;
      end
      if (p_sel && !p_we_n) begin
        wp_cnt++; wp_addr = p_addr; wp_data = p_dq;
        chk(p_dq_oe, "R6 data not driven in pulse", p_dq_oe, 1);
      end else if (wp_cnt > 0) begin
        chk(wp_cnt == WP, "R5 write pulse width", wp_cnt, WP);
        mem_arr[int'(wp_addr)] = wp_data;
        wp_cnt = 0;
      end
      chk(!(p_sel && !p_oe_n && p_we_n && p_dq_oe), "R8 contention", p_dq_oe, 0);
      if (p_dq_oe && !p_oe_n) floatc = 0;
      if (!p_oe_n) floatc = 0; else if (floatc < 100) floatc++;
    end
    if (p_sel && !p_oe_n && p_we_n) age++; else age = 0;

    cur_sel = !mem_ce1_n && mem_ce2;
    if (!rst && mem_dq_oe && !p_dq_oe)
      chk(floatc >= TA + 1, "R8 driver too soon after read", floatc, TA + 1);
    p_sel = cur_sel; p_oe_n = mem_oe_n; p_we_n = mem_we_n; p_dq_oe = mem_dq_oe;
    p_addr = mem_addr; p_dq = mem_dq_out;
    mem_dq_in = (cur_sel && !mem_oe_n && mem_we_n && age >= RD - 1) ?
                mem_rd(int'(mem_addr)) : 8'hEE;

    // ---------- pin compare against the reference model ----------
    exp_sel = (ph == 1) || (ph == 3) || (ph == 4) || (ph == 5);
    chk(mem_ce1_n == !exp_sel && mem_ce2 == exp_sel, (ph == 5) ? "R7 select" : "R2 select",
        {mem_ce1_n, mem_ce2}, {!exp_sel, exp_sel});
    chk(mem_oe_n == !(ph == 1), "R3 output enable", mem_oe_n, !(ph == 1));
    chk(mem_we_n == !(ph == 4), "R5 write strobe", mem_we_n, !(ph == 4));
    chk(mem_dq_oe == (ph >= 3 && ph <= 5), "R8 driver enable", mem_dq_oe, (ph >= 3 && ph <= 5));
    rtag = (ph == 7) ? "R11 ready during wake" : "R9 ready";
    chk(req_ready == (ph == 0 && !sleep_req), rtag, req_ready, (ph == 0 && !sleep_req));
    chk(sleep_ack == (ph == 6), "R10 sleep_ack", sleep_ack, (ph == 6));
    chk(rsp_valid == rsp_exp, "R4 rsp_valid", rsp_valid, rsp_exp);
    if (rsp_exp) chk(rsp_rdata == rsp_dat, "R4 read data", rsp_rdata, rsp_dat);
    if (exp_sel) chk(mem_addr == lat_addr, "R6 address", mem_addr, lat_addr);
    if (ph >= 3 && ph <= 5) chk(mem_dq_out == lat_data, "R6 write data", mem_dq_out, lat_data);
  end

  task automatic do_req(input bit wr, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe,
        "R1 pins in reset", {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
    chk(!rsp_valid && !sleep_ack && req_ready, "R1 handshake in reset",
        {rsp_valid, sleep_ack, req_ready}, 3'b001);
    rst = 0;

    // writes at corner addresses, then read-back
    do_req(1, 16'h0000, 8'h3C);
    do_req(1, 16'hFFFF, 8'hC3);
    do_req(1, 16'h1234, 8'h5A);
    do_req(0, 16'hFFFF, 8'h00);
    do_req(0, 16'h0000, 8'h00);
    // read followed at once by write (turnaround), then write then read
    do_req(1, 16'h0000, 8'h81);
    do_req(0, 16'h0000, 8'h00);
    do_req(0, 16'h4321, 8'h00);
    do_req(0, 16'h1234, 8'h00);
    for (int i = 1; i < 7; i++) begin
      do_req(1, 16'(i * 16'h1111), 8'(i * 37));
      do_req(0, 16'(i * 16'h1111), 8'h00);
    end

    // R10: retention request in the same cycle as a new write request
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 16'hBEEF; req_wdata = 8'h77;
    sleep_req = 1;
    repeat (20) @(negedge clk);
    sleep_req = 0;
    // R11: pending request taken only after the recovery wait
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 0;
    do_req(0, 16'hBEEF, 8'h00);

    // R10: retention request arriving mid-read
    do_req(0, 16'h2222, 8'h00);
    repeat (2) @(negedge clk);
    sleep_req = 1;
    repeat (30) @(negedge clk);
    sleep_req = 0;
    repeat (RV + 5) @(negedge clk);
    do_req(0, 16'h3333, 8'h00);
    repeat (40) @(negedge clk);
    finish_run;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    finish_run;
  end

endmodule